// File: doc/BRIEF.md
# Up/Down Interval Timer with Center-Aligned Counting

This block is a free-running interval timer for general use. It has a counter, a reload limit, one compare channel and a small register port. The counter can run in one direction and wrap, or it can sweep up and down between zero and the reload limit. There are three variants of the up/down sweep. They differ only in which sweep direction may raise the compare flag. Each wrap or turn-around is an update event. An update event can load a buffered reload value, raise an update flag and, in single-shot operation, stop the timer.

Software drives the block through a word-indexed register port that takes 16-bit or 32-bit writes. A separate strobe, `sample_tick`, gives a divided sampling rate for filter logic outside the block. An option returns the update flag in the top bit of the counter readback, so one read gives both the count and the wrap status.

Top module: `updown_timer`

## Requirements
- R1: After reset, every register reads zero. In the control word (register 0), bits 15:12, 10 and 7 always read 0. The control bits are: 0 run, 1 update-disable, 2 single-shot, 3 direction (1 = down), 5:4 counting scheme, 6 reload buffering, 9:8 sampling divider, 11 flag-in-counter.
- R2: Register indices are 0 control, 1 status, 2 counter, 3 reload, 4 compare. A write with `bus_wide`=1 replaces all 32 bits. A write with `bus_wide`=0 replaces only bits 15:0 and keeps the upper half.
- R3: Scheme 00 counting up runs 0,1,…,L (L is the active reload limit). It then returns to 0, and that return is an update event.
- R4: Scheme 00 counting down steps down to 0. It then loads L, and that load is an update event.
- R5: Schemes 01, 10 and 11 sweep up to L, turn down, sweep down to 0 and turn up. Each turn is an update event. In these schemes, control bit 3 reads the current direction, and writes to bit 3 are ignored.
- R6: A control write is discarded entirely when the timer is running in scheme 00 and the write would select a scheme other than 00.
- R7: Status bit 1 (compare flag) is set when the running counter equals the compare value. Scheme 01 allows this only while counting down. Scheme 10 allows it only while counting up. Schemes 00 and 11 allow it in either direction.
- R8: With reload buffering off, a reload write takes effect at once. With it on, the write goes to a buffer that becomes active at the next update event. Register 3 reads back the last written value.
- R9: An update event sets status bit 0 (update flag) unless update-disable is 1. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: In single-shot operation, the run bit clears itself at the update event.
- R11: When bit 11 is 1, counter readback bit 31 shows the update flag. When bit 11 is 0, readback bit 31 is the counter's own bit.
- R12: `sample_tick` pulses every cycle for divider code 00, every 2nd cycle for 01 and every 4th cycle for 10. Reserved code 11 behaves like 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wide | input | 1 | 1 = 32-bit write, 0 = 16-bit write to the low half |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| upd_flag | output | 1 | Update flag |
| cmp_flag | output | 1 | Compare flag |
| sample_tick | output | 1 | Divided sampling strobe |

## Verification
Some rules are checked on every cycle, because each can be stated across one clock edge. These are the wrap to zero when counting up, the reload when counting down, the turn from up to down, the hold of the active limit while buffering is on, the discarding of a scheme change while running, the single-shot stop, the update flag held off by update-disable, the compare flag held off in the wrong direction, and the full-rate strobe. Other behaviour needs whole scenarios, and only the bench's sweeps over small reload limits show it. These are the complete count sequences, the time at which a flag first appears under each scheme, the effect of the 16-bit write merge, the readback layout and reserved bits, the flag-in-counter readback, and the strobe rates.

// File: rtl/updown_timer_pkg.sv
`timescale 1ns/1ps
// Shared types for the up/down timer: counting schemes, register indices
// and the decoded control word. Assumes a 3-bit word-indexed register port.
package updown_timer_pkg;
    typedef enum logic [1:0] {
        MODE_EDGE  = 2'b00,
        MODE_CDOWN = 2'b01,
        MODE_CUP   = 2'b10,
        MODE_CBOTH = 2'b11
    } cnt_mode_e;

    localparam int          ADDR_W   = 3;
    localparam logic [2:0]  A_CTRL   = 3'd0;
    localparam logic [2:0]  A_STAT   = 3'd1;
    localparam logic [2:0]  A_CNT    = 3'd2;
    localparam logic [2:0]  A_RELOAD = 3'd3;
    localparam logic [2:0]  A_CMP    = 3'd4;

    typedef struct packed {
        logic       remap;
        logic [1:0] clkdiv;
        logic       preload;
        cnt_mode_e  mode;
        logic       dir;
        logic       opm;
        logic       updis;
        logic       run;
    } ctrl_t;
endpackage

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
// Control word holder. It decodes a 16-bit control write and discards a
// write that would leave edge counting while the timer runs. In the
// up/down schemes the direction bit is not writable. Single-shot stop
// clears the run bit. Assumes at most one write per cycle.
module tmr_ctrl
    import updown_timer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    input  logic        run_clr,
    input  logic        dir_now,
    output ctrl_t       cfg,
    output logic [15:0] rd_val
);
    ctrl_t     new_cfg;
    cnt_mode_e new_mode;
    logic      reject;
    logic      unused_bits;

    assign unused_bits = ^{wdata[15:12], wdata[10], wdata[7]};
    assign new_mode    = cnt_mode_e'(wdata[5:4]);

    // Decode the write data into a candidate control word.
    always_comb begin
        new_cfg.run     = wdata[0];
        new_cfg.updis   = wdata[1];
        new_cfg.opm     = wdata[2];
        new_cfg.mode    = new_mode;
        new_cfg.dir     = (new_mode != MODE_EDGE) ? cfg.dir : wdata[3];
        new_cfg.preload = wdata[6];
        new_cfg.clkdiv  = wdata[9:8];
        new_cfg.remap   = wdata[11];
    end

    // Flag a write that would leave edge counting while running.
    assign reject = cfg.run && (cfg.mode == MODE_EDGE) && (new_mode != MODE_EDGE);

    // Hold the control word; an accepted write wins over single-shot stop.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cfg <= '0;
        else if (wr_en && !reject)  cfg <= new_cfg;
        else if (run_clr)           cfg.run <= 1'b0;
    end

    // Build the readback; the up/down schemes show the live direction.
    always_comb begin
        rd_val = {4'b0, cfg.remap, 1'b0, cfg.clkdiv, 1'b0, cfg.preload,
                  cfg.mode, (cfg.mode != MODE_EDGE) ? dir_now : cfg.dir,
                  cfg.opm, cfg.updis, cfg.run};
    end

    a_r6_no_scheme_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg.run && cfg.mode == MODE_EDGE && wdata[5:4] != 2'b00)
        |=> (cfg.mode == MODE_EDGE));

    a_r10_single_shot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (run_clr && !wr_en) |=> !cfg.run);
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
// Counter, direction state and reload registers. Edge counting wraps at
// the limit or at zero. The up/down schemes turn around at both ends.
// Every wrap or turn is a turn event, and it becomes an update event
// unless update-disable is set. A counter write overrides counting.
module tmr_core
    import updown_timer_pkg::*;
#(
    parameter int CNT_W = 32
)(
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            cfg,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wval,
    input  logic             arr_wr,
    input  logic [CNT_W-1:0] arr_wval,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] arr_shadow,
    output logic [CNT_W-1:0] arr_act,
    output logic             count_down,
    output logic             uev
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             dir_q;
    logic             center;
    logic             at_top;
    logic             at_bot;
    logic             turn;
    logic [CNT_W-1:0] cnt_next;

    assign center     = (cfg.mode != MODE_EDGE);
    assign count_down = center ? dir_q : cfg.dir;
    assign at_top     = (cnt_q == arr_act);
    assign at_bot     = (cnt_q == '0);
    assign turn       = cfg.run && (count_down ? at_bot : at_top);
    assign uev        = turn && !cfg.updis;

    // Choose the next count from the scheme, direction and end points.
    always_comb begin
        if (!count_down) begin
            if (at_top) cnt_next = center ? ((arr_act == '0) ? '0 : arr_act - ONE) : '0;
            else        cnt_next = cnt_q + ONE;
        end else begin
            if (at_bot) cnt_next = center ? ((arr_act == '0) ? '0 : ONE) : arr_act;
            else        cnt_next = cnt_q - ONE;
        end
    end

    // Counter register: a write wins, otherwise advance while running.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cnt_wr)   cnt_q <= cnt_wval;
        else if (cfg.run)  cnt_q <= cnt_next;
    end

    // Direction state: flips at turns in up/down schemes, else follows control.
    always_ff @(posedge clk) begin
        if (!rst_n)       dir_q <= 1'b0;
        else if (center)  dir_q <= turn ? ~dir_q : dir_q;
        else              dir_q <= cfg.dir;
    end

    // Reload buffer: holds the last written limit.
    always_ff @(posedge clk) begin
        if (!rst_n)      arr_shadow <= '0;
        else if (arr_wr) arr_shadow <= arr_wval;
    end

    // Active limit: direct write when unbuffered, buffer copy on update event.
    always_ff @(posedge clk) begin
        if (!rst_n)                       arr_act <= '0;
        else if (arr_wr && !cfg.preload)  arr_act <= arr_wval;
        else if (uev && cfg.preload)      arr_act <= arr_shadow;
    end

    a_r3_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.run && !center && !cfg.dir && at_top && !cnt_wr) |=> (cnt_q == '0));

    a_r4_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.run && !center && cfg.dir && at_bot && !cnt_wr) |=> (cnt_q == $past(arr_act)));

    a_r5_turn_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.run && center && !dir_q && at_top) |=> dir_q);

    a_r8_buffer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.preload && !uev) |=> $stable(arr_act));
endmodule

// File: rtl/tmr_compare.sv
`timescale 1ns/1ps
// Compare match for the single channel. A match counts only while the
// timer runs and the current direction is one the scheme allows.
// Purely combinational; the flag register lives in the top level.
module tmr_compare
    import updown_timer_pkg::*;
#(
    parameter int CNT_W = 32
)(
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] ccr,
    input  cnt_mode_e        mode,
    input  logic             count_down,
    input  logic             run,
    output logic             hit
);
    logic dir_ok;

    // Pick the allowed direction for the scheme.
    always_comb begin
        case (mode)
            MODE_CDOWN: dir_ok = count_down;
            MODE_CUP:   dir_ok = !count_down;
            default:    dir_ok = 1'b1;
        endcase
    end

    assign hit = run && dir_ok && (cnt_q == ccr);
endmodule

// File: rtl/tmr_clkdiv.sv
`timescale 1ns/1ps
// Sampling strobe generator. A free-running counter gives a strobe at the
// full, half or quarter timer rate. The reserved code gives the full rate.
module tmr_clkdiv #(
    parameter int DIV_W = 2
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [DIV_W-1:0] ctr;

    // Free-running phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) ctr <= '0;
        else        ctr <= ctr + DIV_W'(1);
    end

    // Decode the strobe for the selected ratio.
    always_comb begin
        case (sel)
            2'b01:   tick = (ctr[0] == 1'b0);
            2'b10:   tick = (ctr[1:0] == 2'b00);
            default: tick = 1'b1;
        endcase
    end

    a_r12_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |-> tick);
endmodule

// File: rtl/updown_timer.sv
`timescale 1ns/1ps
// Top level of the up/down timer. It decodes register writes, merges
// 16-bit writes into the low half, holds the compare value and the two
// status flags, and muxes the readback. Assumes CNT_W is 17 to 32.
module updown_timer
    import updown_timer_pkg::*;
#(
    parameter int CNT_W = 32
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_wide,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        upd_flag,
    output logic        cmp_flag,
    output logic        sample_tick
);
    ctrl_t            cfg;
    logic [15:0]      ctrl_rd;
    logic             ctrl_wr, stat_wr, cnt_wr, arr_wr, ccr_wr;
    logic [CNT_W-1:0] cnt_q, arr_shadow, arr_act, ccr_q;
    logic [CNT_W-1:0] cnt_wval, arr_wval, ccr_wval;
    logic             count_down, uev, hit;
    logic [31:0]      cnt_rb;

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign stat_wr = bus_wr && (bus_addr == A_STAT);
    assign cnt_wr  = bus_wr && (bus_addr == A_CNT);
    assign arr_wr  = bus_wr && (bus_addr == A_RELOAD);
    assign ccr_wr  = bus_wr && (bus_addr == A_CMP);

    // Merge a 16-bit write into the low half of each wide register.
    always_comb begin
        cnt_wval = bus_wide ? bus_wdata[CNT_W-1:0] : {cnt_q[CNT_W-1:16],      bus_wdata[15:0]};
        arr_wval = bus_wide ? bus_wdata[CNT_W-1:0] : {arr_shadow[CNT_W-1:16], bus_wdata[15:0]};
        ccr_wval = bus_wide ? bus_wdata[CNT_W-1:0] : {ccr_q[CNT_W-1:16],      bus_wdata[15:0]};
    end

    tmr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(bus_wdata[15:0]),
        .run_clr(uev && cfg.opm), .dir_now(count_down), .cfg(cfg), .rd_val(ctrl_rd)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .cnt_wr(cnt_wr), .cnt_wval(cnt_wval), .arr_wr(arr_wr), .arr_wval(arr_wval),
        .cnt_q(cnt_q), .arr_shadow(arr_shadow), .arr_act(arr_act),
        .count_down(count_down), .uev(uev)
    );

    tmr_compare #(.CNT_W(CNT_W)) u_cmp (
        .cnt_q(cnt_q), .ccr(ccr_q), .mode(cfg.mode), .count_down(count_down),
        .run(cfg.run), .hit(hit)
    );

    tmr_clkdiv #(.DIV_W(2)) u_div (
        .clk(clk), .rst_n(rst_n), .sel(cfg.clkdiv), .tick(sample_tick)
    );

    // Compare value register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ccr_q <= '0;
        else if (ccr_wr) ccr_q <= ccr_wval;
    end

    // Status flags: an event sets, a write of 1 clears, and a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_flag <= 1'b0;
            cmp_flag <= 1'b0;
        end else begin
            if (uev)                       upd_flag <= 1'b1;
            else if (stat_wr && bus_wdata[0]) upd_flag <= 1'b0;
            if (hit)                       cmp_flag <= 1'b1;
            else if (stat_wr && bus_wdata[1]) cmp_flag <= 1'b0;
        end
    end

    // Counter readback with optional update flag in the top bit.
    always_comb begin
        cnt_rb = 32'(cnt_q);
        if (cfg.remap) cnt_rb[31] = upd_flag;
    end

    // Readback multiplexer.
    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = {16'b0, ctrl_rd};
            A_STAT:   bus_rdata = {30'b0, cmp_flag, upd_flag};
            A_CNT:    bus_rdata = cnt_rb;
            A_RELOAD: bus_rdata = 32'(arr_shadow);
            A_CMP:    bus_rdata = 32'(ccr_q);
            default:  bus_rdata = '0;
        endcase
    end

    a_r9_disable_holds_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.updis && !upd_flag) |=> !upd_flag);

    a_r7_up_scheme_skips_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == MODE_CUP && count_down && !cmp_flag) |=> !cmp_flag);
endmodule

// File: tb/sim_updown_timer.sv
`timescale 1ns/1ps
module sim_updown_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_wr = 1'b0;
    logic        bus_wide = 1'b1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        upd_flag, cmp_flag, sample_tick;

    int vec = 0;
    int miss = 0;
    bit done = 1'b0;

    localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, CNT = 3'd2, RLD = 3'd3, CMPR = 3'd4;

    always #2 clk = ~clk;

    updown_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd_flag(upd_flag), .cmp_flag(cmp_flag), .sample_tick(sample_tick)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic w);
        bus_addr = a; bus_wdata = d; bus_wide = w; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0; bus_wide = 1'b1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fresh(input logic [31:0] lim);
        wr(CTRL, 32'h0, 1'b1);
        wr(RLD, lim, 1'b1);
        wr(CNT, 32'h0, 1'b1);
        wr(STAT, 32'h3, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, e;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state and reserved bits
        rd(CTRL, v); chk("R1 ctrl reset", v, 32'h0);
        rd(STAT, v); chk("R1 status reset", v, 32'h0);
        rd(CNT, v);  chk("R1 counter reset", v, 32'h0);
        rd(RLD, v);  chk("R1 reload reset", v, 32'h0);
        wr(CTRL, 32'h0000FFFF, 1'b1);
        rd(CTRL, v); chk("R1 reserved bits", v, 32'h00000B77);
        wr(CTRL, 32'h0, 1'b1);

        // R2: wide and narrow writes
        wr(CNT, 32'h12345678, 1'b1);
        rd(CNT, v); chk("R2 wide write", v, 32'h12345678);
        wr(CNT, 32'hFFFFABCD, 1'b0);
        rd(CNT, v); chk("R2 narrow write keeps upper", v, 32'h1234ABCD);
        wr(RLD, 32'h99990007, 1'b0);
        rd(RLD, v); chk("R2 narrow reload", v, 32'h00000007);

        // R3: edge counting up, sweep of limits
        for (int n = 1; n <= 5; n++) begin
            fresh(n);
            wr(CTRL, 32'h0001, 1'b1);
            for (int k = 0; k <= 2*n + 3; k++) begin
                if (k > 0) tick();
                rd(CNT, v); chk("R3 up count", v, 32'(k % (n + 1)));
                chk("R3 update event flag", 32'(upd_flag), 32'(k >= n + 1));
            end
        end

        // R4: edge counting down
        for (int n = 1; n <= 5; n++) begin
            fresh(n);
            wr(CTRL, 32'h0009, 1'b1);
            for (int k = 0; k <= 2*n + 3; k++) begin
                if (k > 0) tick();
                rd(CNT, v); chk("R4 down count", v, 32'((n + 1 - (k % (n + 1))) % (n + 1)));
                chk("R4 update event flag", 32'(upd_flag), 32'(k >= 1));
            end
        end

        // R5: up/down sweep, direction readback, direction write ignored
        for (int n = 2; n <= 5; n++) begin
            fresh(n);
            wr(CTRL, 32'h0019, 1'b1);
            for (int k = 0; k <= 4*n + 1; k++) begin
                int p;
                if (k > 0) tick();
                p = k % (2*n);
                rd(CNT, v); chk("R5 sweep count", v, 32'((p <= n) ? p : 2*n - p));
                rd(CTRL, v); chk("R5 direction readback", 32'(v[3]), 32'((p > n) || (p == 0 && k > 0)));
                chk("R5 update at turn", 32'(upd_flag), 32'(k >= n + 1));
            end
        end

        // R6: scheme switch while running is discarded
        fresh(5);
        wr(CTRL, 32'h0001, 1'b1);
        wr(CTRL, 32'h0011, 1'b1);
        rd(CTRL, v); chk("R6 write discarded", v, 32'h0001);
        wr(CTRL, 32'h0, 1'b1);
        wr(CTRL, 32'h0010, 1'b1);
        rd(CTRL, v); chk("R6 accepted when stopped", v, 32'h0010);

        // R7: compare flag direction per scheme, limit 5, compare 2
        for (int m = 0; m < 4; m++) begin
            int first;
            first = (m == 1) ? 9 : 3;
            fresh(5);
            wr(CMPR, 32'd2, 1'b1);
            wr(CTRL, 32'(1 + (m << 4)), 1'b1);
            for (int k = 0; k <= 12; k++) begin
                if (k > 0) tick();
                chk($sformatf("R7 compare flag scheme %0d", m), 32'(cmp_flag), 32'(k >= first));
            end
        end

        // R8: buffered reload takes effect at update event
        fresh(3);
        wr(CTRL, 32'h0041, 1'b1);
        for (int k = 0; k <= 11; k++) begin
            int kk;
            if (k == 1) begin
                bus_addr = RLD; bus_wdata = 32'd6; bus_wide = 1'b1; bus_wr = 1'b1;
            end
            tick();
            bus_wr = 1'b0;
            kk = k + 1;
            rd(CNT, v); chk("R8 buffered reload", v, 32'((kk <= 3) ? kk : (kk - 4) % 7));
        end
        rd(RLD, v); chk("R8 reload readback", v, 32'd6);
        fresh(3);
        wr(CTRL, 32'h0001, 1'b1);
        for (int k = 0; k <= 11; k++) begin
            if (k == 1) begin
                bus_addr = RLD; bus_wdata = 32'd6; bus_wide = 1'b1; bus_wr = 1'b1;
            end
            tick();
            bus_wr = 1'b0;
            rd(CNT, v); chk("R8 direct reload", v, 32'((k + 1) % 7));
        end

        // R9: update-disable and write-1-to-clear
        fresh(2);
        wr(CTRL, 32'h0003, 1'b1);
        for (int k = 1; k <= 8; k++) begin
            tick();
            rd(CNT, v); chk("R9 count with update disabled", v, 32'(k % 3));
            chk("R9 no update flag", 32'(upd_flag), 32'h0);
        end
        fresh(2);
        wr(CTRL, 32'h0001, 1'b1);
        repeat (4) tick();
        wr(CTRL, 32'h0, 1'b1);
        rd(STAT, v); chk("R9 flag set", 32'(v[0]), 32'h1);
        wr(STAT, 32'h0, 1'b1);
        rd(STAT, v); chk("R9 write 0 keeps flag", 32'(v[0]), 32'h1);
        wr(STAT, 32'h1, 1'b1);
        rd(STAT, v); chk("R9 write 1 clears flag", 32'(v[0]), 32'h0);

        // R10: single-shot stops at update event
        fresh(3);
        wr(CTRL, 32'h0005, 1'b1);
        for (int k = 1; k <= 8; k++) begin
            tick();
            rd(CNT, v); chk("R10 single-shot count", v, 32'((k <= 3) ? k : 0));
            rd(CTRL, v); chk("R10 run bit", 32'(v[0]), 32'(k < 4));
        end

        // R11: flag in counter top bit
        wr(CNT, 32'h00000005, 1'b1);
        wr(CTRL, 32'h0800, 1'b1);
        rd(CNT, v); chk("R11 flag shown", v, 32'h80000005);
        wr(STAT, 32'h1, 1'b1);
        rd(CNT, v); chk("R11 flag clear shown", v, 32'h00000005);
        wr(CTRL, 32'h0, 1'b1);
        wr(CNT, 32'h80000005, 1'b1);
        rd(CNT, v); chk("R11 own bit without option", v, 32'h80000005);
        wr(CTRL, 32'h0800, 1'b1);
        rd(CNT, v); chk("R11 own bit hidden", v, 32'h00000005);

        // R12: sampling strobe rates
        for (int c = 0; c < 4; c++) begin
            int n;
            n = 0;
            wr(CTRL, 32'(c << 8), 1'b1);
            for (int i = 0; i < 16; i++) begin
                if (sample_tick) n++;
                tick();
            end
            e = (c == 1) ? 32'd8 : (c == 2) ? 32'd4 : 32'd16;
            chk($sformatf("R12 strobe count code %0d", c), 32'(n), e);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end
endmodule